// File: doc/BRIEF.md
# Header-Selected Serial Register Access Slave

This block terminates a four-wire host control link: an active-low chip select, a serial clock that idles low, a serial data input and a serial data output that can be switched off. It converts the serial traffic into single-cycle read and write strobes on an internal register port. All four serial lines are resynchronised into the block clock. Input bits are taken on rising serial clock edges and output bits change on falling edges. Every byte is shifted most significant bit first.

The first byte of each selected frame is a header that chooses one of three framings:
- **Paired framing (0x40).** An address byte and its data byte alternate. Read data goes out only in a slot of its own, so the two data lines may share one wire.
- **Overlapped framing (0x48).** The read data for one address goes out while the next address byte comes in.
- **Burst framing (0x43).** One address byte is followed by any number of data bytes. When that address selects the FIFO window, the port carries a FIFO flag and a 5-bit location pointer that steps once per data byte.

Top module: `sreg_slave`

## Requirements
- R1: Header 0x40. An address byte is bit 7 = direction (0 write, 1 read) with the register index in bits 6:0. A write address byte followed by a data byte gives exactly one `reg_wr` pulse carrying that index and that data.
- R2: Header 0x40, read address byte. The block gives one `reg_rd` pulse, and the whole next byte slot carries the returned data on `sdo`, MSB first, with `sdo_oe` high. The byte received in that slot is discarded. The byte after it is treated as a new address.
- R3: Header 0x48. After a read address, the next slot drives the returned data on `sdo` while the byte received in that same slot is decoded as the next address.
- R4: Header 0x43 with a FIFO-window index (0x00 to 0x1F, 0x6A or 0x7A) and a write direction. Each data byte gives one `reg_wr` with `fifo_sel` high. `fifo_ptr` reads 0, 1, 2 and so on, wraps from 31 to 0, and starts again at 0 in every 0x43 frame.
- R5: Header 0x43 with a FIFO-window index and a read direction. The data slots return consecutive FIFO locations, starting at location 0.
- R6: Header 0x43 with an index outside the FIFO window. Every data byte accesses the same register with `fifo_sel` low.
- R7: A rising chip select ends the frame. A partially shifted byte gives no strobe. The next frame starts again with a header byte.
- R8: An unknown header value suppresses every strobe, and keeps `sdo_oe` low, until chip select rises.
- R9: `sdo_oe` is low in header slots, address slots that carry no read data, and write data slots.
- R10: `reg_wr` and `reg_rd` are never high together, and each lasts exactly one clock.
- R11: After reset, no strobe is active, `sdo_oe` is low and `fifo_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; must run at least 8 times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| sclk | input | 1 | Host serial clock, idles low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |
| reg_wr | output | 1 | One-clock register write strobe |
| reg_rd | output | 1 | One-clock register read strobe |
| reg_addr | output | 7 | Register index of the current access |
| reg_wdata | output | 8 | Write data qualified by `reg_wr` |
| reg_rdata | input | 8 | Read data, valid in the clock after `reg_rd` |
| fifo_sel | output | 1 | Access targets the FIFO location given by `fifo_ptr` |
| fifo_ptr | output | 5 | FIFO location of the current burst access |

## Verification
The overlapped header is the case where two jobs share one byte slot. The data returned for a read leaves on `sdo` while the next address enters on `sdi`. The test provokes this by sending two read addresses back to back and then a write address. It judges the result by the byte captured during each of those slots, and by the write data landing at the address that was shifted in during an output slot. A second overlap, chip select rising part-way through a byte, is provoked with a 4-bit truncated byte and judged by the strobe count and the untouched register.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;

    localparam logic [BYTE_W-1:0] HDR_PAIRED  = 8'h40;
    localparam logic [BYTE_W-1:0] HDR_OVERLAP = 8'h48;
    localparam logic [BYTE_W-1:0] HDR_BURST   = 8'h43;

    typedef enum logic [1:0] {
        M_PAIRED,
        M_OVERLAP,
        M_BURST
    } mode_e;

    typedef enum logic [2:0] {
        PH_HDR,
        PH_ADDR,
        PH_WDATA,
        PH_RSLOT,
        PH_BURST,
        PH_IGNORE
    } phase_e;

    // Indices that open the FIFO window in burst framing
    function automatic logic fifo_mapped(input logic [ADDR_W-1:0] idx);
        return (idx < 7'h20) || (idx == 7'h6A) || (idx == 7'h7A);
    endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sreg_bitio.sv
module sreg_bitio
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_data,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-2:0] rx;
        logic [BYTE_W-1:0] tx;
        logic              pend;
        logic              oe;
        logic              out;
    } bit_st_t;

    bit_st_t bit_d, bit_q;
    logic    rise, fall;

    always_comb begin
        rise      = cs_act & sclk_s & ~bit_q.sclk_prev;
        fall      = cs_act & ~sclk_s & bit_q.sclk_prev;
        byte_done = rise && (bit_q.cnt == LAST_BIT);
        rx_byte   = {bit_q.rx, sdi_s};

        bit_d           = bit_q;
        bit_d.sclk_prev = sclk_s;

        if (!cs_act) begin
            bit_d.cnt  = '0;
            bit_d.pend = 1'b0;
            bit_d.oe   = 1'b0;
            bit_d.out  = 1'b0;
        end else begin
            if (rise) begin
                bit_d.cnt = bit_q.cnt + 1'b1;
                bit_d.rx  = {bit_q.rx[BYTE_W-3:0], sdi_s};
            end
            if (fall) begin
                if (bit_q.cnt == '0) begin
                    // falling edge that opens a new byte slot
                    if (bit_q.pend) begin
                        bit_d.oe   = 1'b1;
                        bit_d.out  = bit_q.tx[BYTE_W-1];
                        bit_d.tx   = {bit_q.tx[BYTE_W-2:0], 1'b0};
                        bit_d.pend = 1'b0;
                    end else begin
                        bit_d.oe = 1'b0;
                    end
                end else if (bit_q.oe) begin
                    bit_d.out = bit_q.tx[BYTE_W-1];
                    bit_d.tx  = {bit_q.tx[BYTE_W-2:0], 1'b0};
                end
            end
            if (load_en) begin
                bit_d.tx   = load_data;
                bit_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= '0;
        else        bit_q <= bit_d;
    end

    assign sdo    = bit_q.out;
    assign sdo_oe = bit_q.oe;

endmodule

// File: rtl/sreg_seq.sv
module sreg_seq
    import sreg_pkg::*;
#(
    parameter int PTR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              fifo_sel,
    output logic [PTR_W-1:0]  fifo_ptr,
    output phase_e            phase
);

    typedef struct packed {
        phase_e            phase;
        mode_e             mode;
        logic              is_rd;
        logic [ADDR_W-1:0] addr;
        logic              fsel;
        logic [PTR_W-1:0]  ptr;
        logic [PTR_W-1:0]  sptr;
        logic              wr;
        logic              rd;
        logic [BYTE_W-1:0] wdata;
    } seq_st_t;

    seq_st_t seq_d, seq_q;
    logic    mapped;

    always_comb begin
        seq_d    = seq_q;
        seq_d.wr = 1'b0;
        seq_d.rd = 1'b0;
        mapped   = fifo_mapped(rx_byte[ADDR_W-1:0]);

        if (!cs_act) begin
            seq_d.phase = PH_HDR;
        end else if (byte_done) begin
            unique case (seq_q.phase)
                PH_HDR: begin
                    seq_d.phase = PH_ADDR;
                    if (rx_byte == HDR_PAIRED) begin
                        seq_d.mode = M_PAIRED;
                    end else if (rx_byte == HDR_OVERLAP) begin
                        seq_d.mode = M_OVERLAP;
                    end else if (rx_byte == HDR_BURST) begin
                        seq_d.mode = M_BURST;
                        seq_d.ptr  = '0;
                    end else begin
                        seq_d.phase = PH_IGNORE;
                    end
                end
                PH_ADDR: begin
                    seq_d.addr  = rx_byte[ADDR_W-1:0];
                    seq_d.is_rd = rx_byte[BYTE_W-1];
                    seq_d.fsel  = (seq_q.mode == M_BURST) && mapped;
                    if (seq_q.mode == M_BURST)      seq_d.phase = PH_BURST;
                    else if (!rx_byte[BYTE_W-1])    seq_d.phase = PH_WDATA;
                    else if (seq_q.mode == M_PAIRED) seq_d.phase = PH_RSLOT;
                    else                            seq_d.phase = PH_ADDR;
                    if (rx_byte[BYTE_W-1]) begin
                        seq_d.rd = 1'b1;
                        if (seq_d.fsel) begin
                            seq_d.sptr = seq_q.ptr;
                            seq_d.ptr  = seq_q.ptr + 1'b1;
                        end
                    end
                end
                PH_WDATA: begin
                    seq_d.wr    = 1'b1;
                    seq_d.wdata = rx_byte;
                    seq_d.phase = PH_ADDR;
                end
                PH_RSLOT: begin
                    seq_d.phase = PH_ADDR;
                end
                PH_BURST: begin
                    if (seq_q.is_rd) begin
                        seq_d.rd = 1'b1;
                    end else begin
                        seq_d.wr    = 1'b1;
                        seq_d.wdata = rx_byte;
                    end
                    if (seq_q.fsel) begin
                        seq_d.sptr = seq_q.ptr;
                        seq_d.ptr  = seq_q.ptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.phase <= PH_HDR;
            seq_q.mode  <= M_PAIRED;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign reg_wr    = seq_q.wr;
    assign reg_rd    = seq_q.rd;
    assign reg_addr  = seq_q.addr;
    assign reg_wdata = seq_q.wdata;
    assign fifo_sel  = seq_q.fsel;
    assign fifo_ptr  = seq_q.sptr;
    assign phase     = seq_q.phase;

endmodule

// File: rtl/sreg_slave.sv
module sreg_slave
    import sreg_pkg::*;
#(
    parameter int PTR_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              fifo_sel,
    output logic [PTR_W-1:0]  fifo_ptr
);

    logic [2:0]        line_s;
    logic              cs_act;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              rd_dly_d, rd_dly_q;
    phase_e            seq_phase;

    sreg_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, sdi}),
        .q     (line_s)
    );

    assign cs_act = ~line_s[2];

    sreg_bitio u_bitio (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_s    (line_s[1]),
        .sdi_s     (line_s[0]),
        .load_en   (rd_dly_q),
        .load_data (reg_rdata),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    sreg_seq #(
        .PTR_W (PTR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .fifo_sel  (fifo_sel),
        .fifo_ptr  (fifo_ptr),
        .phase     (seq_phase)
    );

    // Read data returns one clock after the strobe; capture it then
    always_comb rd_dly_d = reg_rd & cs_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_dly_q <= 1'b0;
        else        rd_dly_q <= rd_dly_d;
    end

endmodule

// File: rtl/sreg_checker.sv
module sreg_checker
    import sreg_pkg::*;
#(
    parameter int PTR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic             sdo_oe,
    input logic [PTR_W-1:0] fifo_ptr,
    input phase_e           phase
);

    p_rw_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R7: a deselected link produces no strobe and no output drive
    p_cs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
        |-> (!reg_wr && !reg_rd && !sdo_oe));

    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ptr != $past(fifo_ptr))
        |-> ((fifo_ptr == PTR_W'($past(fifo_ptr) + 1'b1)) || (fifo_ptr == '0)));

    p_hdr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HDR) |-> !sdo_oe);

    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IGNORE) |-> (!reg_wr && !reg_rd && !sdo_oe));

endmodule

bind sreg_slave sreg_checker #(
    .PTR_W (PTR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .sdo_oe   (sdo_oe),
    .fifo_ptr (fifo_ptr),
    .phase    (seq_phase)
);

// File: tb/sim_sreg_slave.sv
`timescale 1ns/1ps
module sim_sreg_slave;

    localparam int CLK_P  = 10;
    localparam int HALF   = 8 * CLK_P;
    localparam int LIMIT  = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo, sdo_oe, reg_wr, reg_rd, fifo_sel;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] rdata;
    logic [4:0] fifo_ptr;

    logic [7:0] regs [128];
    logic [7:0] fifo [32];
    int wr_cnt = 0, rd_cnt = 0, clash = 0;
    logic wr_prev = 1'b0, rd_prev = 1'b0;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sreg_slave u0 (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk), .sdi (sdi),
        .sdo (sdo), .sdo_oe (sdo_oe), .reg_wr (reg_wr), .reg_rd (reg_rd),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (rdata),
        .fifo_sel (fifo_sel), .fifo_ptr (fifo_ptr)
    );

    // Register file and FIFO model behind the port
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) regs[i] <= 8'(i * 3 + 1);
            for (int i = 0; i < 32; i++)  fifo[i] <= 8'(8'hC0 + i);
            rdata <= 8'h00;
        end else begin
            if (reg_wr) begin
                if (fifo_sel) fifo[fifo_ptr] <= reg_wdata;
                else          regs[reg_addr] <= reg_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (reg_rd) begin
                rdata  <= fifo_sel ? fifo[fifo_ptr] : regs[reg_addr];
                rd_cnt <= rd_cnt + 1;
            end
            if ((reg_wr && reg_rd) || (reg_wr && wr_prev) || (reg_rd && rd_prev))
                clash <= clash + 1;
            wr_prev <= reg_wr;
            rd_prev <= reg_rd;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame_begin();
        cs_n = 1'b0;
        #(HALF);
    endtask

    task automatic frame_end();
        #(HALF);
        cs_n = 1'b1;
        #(4 * HALF);
    endtask

    // Shift n bits of b, MSB first; report captured output and enable
    task automatic shift_bits(input logic [7:0] b, input int n,
                              output logic [7:0] got, output logic oe_all,
                              output logic oe_any);
        got = 8'h00; oe_all = 1'b1; oe_any = 1'b0;
        for (int i = 7; i > 7 - n; i--) begin
            sdi = b[i];
            #(HALF);
            got[i] = sdo;
            oe_all = oe_all & sdo_oe;
            oe_any = oe_any | sdo_oe;
            sclk = 1'b1;
            #(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic sb(input logic [7:0] b, output logic [7:0] got,
                      output logic oe_all, output logic oe_any);
        shift_bits(b, 8, got, oe_all, oe_any);
    endtask

    task automatic t_reset();
        check("R11 sdo_oe", int'(sdo_oe), 0);
        check("R11 reg_wr", int'(reg_wr), 0);
        check("R11 reg_rd", int'(reg_rd), 0);
        check("R11 fifo_ptr", int'(fifo_ptr), 0);
    endtask

    task automatic t_paired();
        logic [7:0] g; logic oa, on; int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        frame_begin();
        sb(8'h40, g, oa, on); check("R9 header oe", int'(on), 0);
        sb(8'h05, g, oa, on); check("R9 address oe", int'(on), 0);
        sb(8'hA5, g, oa, on); check("R9 write data oe", int'(on), 0);
        sb(8'h10, g, oa, on);
        sb(8'h3C, g, oa, on);
        sb(8'h85, g, oa, on);
        sb(8'hFF, g, oa, on);
        check("R2 read byte", int'(g), 8'hA5);
        check("R2 read slot oe", int'(oa), 1);
        sb(8'h06, g, oa, on); check("R2 oe off after slot", int'(on), 0);
        sb(8'h77, g, oa, on);
        frame_end();
        check("R1 reg 05", int'(regs[5]), 8'hA5);
        check("R1 reg 10", int'(regs[16]), 8'h3C);
        check("R2 byte after slot is address", int'(regs[6]), 8'h77);
        check("R1 write count", wr_cnt - w0, 3);
        check("R2 read count", rd_cnt - r0, 1);
    endtask

    task automatic t_overlap();
        logic [7:0] g; logic oa, on; int r0;
        r0 = rd_cnt;
        frame_begin();
        sb(8'h48, g, oa, on);
        sb(8'h20, g, oa, on); sb(8'h11, g, oa, on);
        sb(8'h21, g, oa, on); sb(8'h22, g, oa, on);
        sb(8'hA0, g, oa, on);
        sb(8'hA1, g, oa, on);
        check("R3 data with next address", int'(g), 8'h11);
        check("R3 oe", int'(oa), 1);
        sb(8'h22, g, oa, on);
        check("R3 second overlapped byte", int'(g), 8'h22);
        sb(8'h99, g, oa, on);
        check("R9 overlap write data oe", int'(on), 0);
        frame_end();
        check("R3 write after overlap", int'(regs[34]), 8'h99);
        check("R3 read count", rd_cnt - r0, 2);
    endtask

    task automatic t_burst_wr();
        logic [7:0] g; logic oa, on;
        frame_begin();
        sb(8'h43, g, oa, on);
        sb(8'h05, g, oa, on);
        for (int k = 0; k < 34; k++) sb(8'(k + 1), g, oa, on);
        frame_end();
        check("R4 wrap loc0", int'(fifo[0]), 8'h21);
        check("R4 wrap loc1", int'(fifo[1]), 8'h22);
        check("R4 loc2", int'(fifo[2]), 8'h03);
        check("R4 loc31", int'(fifo[31]), 8'h20);
        check("R4 last pointer", int'(fifo_ptr), 1);
        frame_begin();
        sb(8'h43, g, oa, on);
        sb(8'h6A, g, oa, on);
        sb(8'hAA, g, oa, on);
        sb(8'hBB, g, oa, on);
        frame_end();
        check("R4 restart loc0", int'(fifo[0]), 8'hAA);
        check("R4 restart loc1", int'(fifo[1]), 8'hBB);
        check("R4 restart loc2 kept", int'(fifo[2]), 8'h03);
    endtask

    task automatic t_burst_rd();
        logic [7:0] g; logic oa, on;
        logic [7:0] exp_v [4];
        exp_v[0] = 8'hAA; exp_v[1] = 8'hBB; exp_v[2] = 8'h03; exp_v[3] = 8'h04;
        frame_begin();
        sb(8'h43, g, oa, on);
        sb(8'hFA, g, oa, on);
        for (int k = 0; k < 4; k++) begin
            sb(8'h00, g, oa, on);
            check("R5 burst read byte", int'(g), int'(exp_v[k]));
            check("R5 burst read oe", int'(oa), 1);
        end
        frame_end();
    endtask

    task automatic t_burst_const();
        logic [7:0] g; logic oa, on; int w0;
        w0 = wr_cnt;
        frame_begin();
        sb(8'h43, g, oa, on);
        sb(8'h30, g, oa, on);
        for (int k = 1; k <= 5; k++) sb(8'(k), g, oa, on);
        frame_end();
        check("R6 constant register", int'(regs[48]), 8'h05);
        check("R6 fifo untouched", int'(fifo[3]), 8'h04);
        check("R6 write count", wr_cnt - w0, 5);
        frame_begin();
        sb(8'h43, g, oa, on);
        sb(8'hB0, g, oa, on);
        sb(8'h00, g, oa, on); check("R6 read 1", int'(g), 8'h05);
        sb(8'h00, g, oa, on); check("R6 read 2", int'(g), 8'h05);
        frame_end();
    endtask

    task automatic t_abort();
        logic [7:0] g; logic oa, on; int w0;
        w0 = wr_cnt;
        frame_begin();
        sb(8'h40, g, oa, on);
        sb(8'h07, g, oa, on);
        shift_bits(8'hF0, 4, g, oa, on);
        frame_end();
        check("R7 partial byte no write", wr_cnt - w0, 0);
        check("R7 register kept", int'(regs[7]), 8'h16);
        frame_begin();
        sb(8'h40, g, oa, on);
        sb(8'h07, g, oa, on);
        sb(8'h5A, g, oa, on);
        frame_end();
        check("R7 new frame header", int'(regs[7]), 8'h5A);
    endtask

    task automatic t_bad_hdr();
        logic [7:0] g; logic oa, on; logic any_oe; int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt; any_oe = 1'b0;
        frame_begin();
        sb(8'h41, g, oa, on); any_oe |= on;
        sb(8'h85, g, oa, on); any_oe |= on;
        sb(8'h00, g, oa, on); any_oe |= on;
        sb(8'h06, g, oa, on); any_oe |= on;
        sb(8'h12, g, oa, on); any_oe |= on;
        frame_end();
        check("R8 no writes", wr_cnt - w0, 0);
        check("R8 no reads", rd_cnt - r0, 0);
        check("R8 output off", int'(any_oe), 0);
        check("R8 register kept", int'(regs[6]), 8'h77);
    endtask

    initial begin
        #(LIMIT * CLK_P);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(3);
        #(4 * CLK_P);
        rst_n = 1'b1;
        #(4 * CLK_P);
        t_reset();
        t_paired();
        t_overlap();
        t_burst_wr();
        t_burst_rd();
        t_burst_const();
        t_abort();
        t_bad_hdr();
        check("R10 strobe overlap or width", clash, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule